// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides which control-memory word a microprogrammed control unit fetches next. It owns the control address register (`car`), which drives the read address of an external control store of 128 words. Each cycle the current microinstruction supplies three fields: a condition selector, a two-bit branch kind and a branch target. The ALU status flags and the opcode from the instruction register are also inputs. On the next rising clock edge the block loads `car` with one of four values: the incremented address, the branch target, an address derived from the opcode, or an address popped from an internal return stack.

The condition selector routes either a constant one or one of the status flags through a multiplexer. Selecting the constant makes a branch unconditional. Subroutine calls push the address that follows the call onto a four-entry last-in-first-out store, and returns pop it back. This allows subroutines to nest up to four levels. When a call finds the store full, or a return finds it empty, a sticky error flag is raised and the sequencer falls through to the next word.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `car` to 0, clears `stackOverflow` and `stackUnderflow`, and empties the return stack.
- R2: When no other rule applies, the next `car` is the current `car` plus one, modulo 128, so 127 is followed by 0. A jump whose condition is false falls through in this way.
- R3: `condSel` encoding: 00 always true, 01 tests `flags[0]`, 10 tests `flags[1]`, 11 tests `flags[2]`. With `brType` = 00 (jump) and the condition true, the next `car` is `brTarget`.
- R4: With `brType` = 01 (call), a true condition and fewer than 4 entries stored, the block pushes `car`+1 and loads `brTarget`. A call with a false condition pushes nothing and falls through.
- R5: With `brType` = 10 (return) and at least one entry stored, the next `car` is the most recently pushed address, which is then removed. Return ignores `condSel` and `flags`.
- R6: With `brType` = 11 (map), the next `car` is {0, `opcode`[3:0], 00}, whatever the condition.
- R7: A true call while 4 entries are stored sets `stackOverflow`, leaves the stack contents unchanged and loads `car`+1.
- R8: A return while the stack is empty sets `stackUnderflow` and loads `car`+1.
- R9: Once set, `stackOverflow` and `stackUnderflow` stay set until reset.
- R10: Four nested calls followed by four returns come back to the four return addresses in reverse order of the calls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| condSel | input | 2 | Condition selector field of the current microinstruction |
| brType | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 map |
| brTarget | input | 7 | Branch target address field |
| flags | input | 3 | ALU status flags |
| opcode | input | 4 | Opcode from the instruction register |
| car | output | 7 | Control address register, read address of control memory |
| stackOverflow | output | 1 | Sticky flag: a call found the return stack full |
| stackUnderflow | output | 1 | Sticky flag: a return found the return stack empty |

## Verification
The bench builds the block with its default parameters: a 7-bit address, a 4-deep return stack, 3 flags and a 4-bit opcode. With these values the address wrap from 127 to 0 can be reached with a single jump. A full stack and an overflow take only five calls. The bench runs a random mix of all four branch kinds with occasional resets, so it frequently passes through full, empty, overflow and underflow states. Directed sequences pin the wrap point, the four-level nesting order and flag stickiness.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } brKind_e;

  typedef enum logic [1:0] {
    SEL_INC = 2'd0,
    SEL_TGT = 2'd1,
    SEL_MAP = 2'd2,
    SEL_POP = 2'd3
  } nextSel_e;

  typedef struct packed {
    nextSel_e sel;
    logic     push;
    logic     pop;
    logic     setOvf;
    logic     setUnf;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int FLAG_W = 3,
  parameter int COND_W = 2
) (
  input  logic [COND_W-1:0] condSel,
  input  logic [1:0]        brType,
  input  logic [FLAG_W-1:0] flags,
  input  logic              stackFull,
  input  logic              stackEmpty,
  output seqStrobe_t        strobe
);

  localparam int CAND_N = FLAG_W + 1;

  logic [CAND_N-1:0] condVec;
  logic              condTrue;
  brKind_e           kind;

  // index 0 is the constant used for unconditional transfers
  assign condVec[0] = 1'b1;
  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_cond
      assign condVec[gi+1] = flags[gi];
    end
  endgenerate

  always_comb begin
    condTrue = 1'b0;
    for (int k = 0; k < CAND_N; k++) begin
      if (condSel == COND_W'(k)) condTrue = condVec[k];
    end
  end

  assign kind = brKind_e'(brType);

  always_comb begin
    strobe = '{sel: SEL_INC, push: 1'b0, pop: 1'b0, setOvf: 1'b0, setUnf: 1'b0};
    unique case (kind)
      BR_JUMP: begin
        if (condTrue) strobe.sel = SEL_TGT;
      end
      BR_CALL: begin
        if (condTrue) begin
          if (stackFull) begin
            strobe.setOvf = 1'b1;
          end else begin
            strobe.push = 1'b1;
            strobe.sel  = SEL_TGT;
          end
        end
      end
      BR_RET: begin
        if (stackEmpty) begin
          strobe.setUnf = 1'b1;
        end else begin
          strobe.pop = 1'b1;
          strobe.sel = SEL_POP;
        end
      end
      BR_MAP: begin
        strobe.sel = SEL_MAP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int OP_W   = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] car,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic              ovfFlag,
  output logic              unfFlag
);

  localparam int PTR_W     = $clog2(DEPTH);
  localparam int MAP_SHIFT = 2;

  logic [ADDR_W-1:0] carInc;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] carNext;
  logic [ADDR_W-1:0] stackMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  topIdx;
  logic              fullBit;

  assign carInc = car + ADDR_W'(1);
  assign topIdx = wrPtr - PTR_W'(1);

  always_comb begin
    mapAddr = '0;
    mapAddr[OP_W+MAP_SHIFT-1:MAP_SHIFT] = opcode;
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_TGT: carNext = brTarget;
      SEL_MAP: carNext = mapAddr;
      SEL_POP: carNext = stackMem[topIdx];
      default: carNext = carInc;
    endcase
  end

  assign stackFull  = fullBit;
  assign stackEmpty = (wrPtr == '0) && !fullBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      car     <= '0;
      wrPtr   <= '0;
      fullBit <= 1'b0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      car <= carNext;
      if (strobe.setOvf) ovfFlag <= 1'b1;
      if (strobe.setUnf) unfFlag <= 1'b1;
      if (strobe.push) begin
        wrPtr <= wrPtr + PTR_W'(1);
        if (wrPtr == PTR_W'(DEPTH - 1)) fullBit <= 1'b1;
      end else if (strobe.pop) begin
        wrPtr   <= topIdx;
        fullBit <= 1'b0;
      end
    end
  end

  genvar si;
  generate
    for (si = 0; si < DEPTH; si++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          stackMem[si] <= '0;
        end else if (strobe.push && wrPtr == PTR_W'(si)) begin
          stackMem[si] <= carInc;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int OP_W   = 4,
  parameter int FLAG_W = 3,
  parameter int COND_W = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] condSel,
  input  logic [1:0]        brType,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [FLAG_W-1:0] flags,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] car,
  output logic              stackOverflow,
  output logic              stackUnderflow
);

  seqStrobe_t strobe;
  logic       stackFull;
  logic       stackEmpty;

  useq_ctrl #(
    .FLAG_W(FLAG_W),
    .COND_W(COND_W)
  ) ctrl_i (
    .condSel   (condSel),
    .brType    (brType),
    .flags     (flags),
    .stackFull (stackFull),
    .stackEmpty(stackEmpty),
    .strobe    (strobe)
  );

  useq_path #(
    .ADDR_W(ADDR_W),
    .OP_W  (OP_W),
    .DEPTH (DEPTH)
  ) path_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .brTarget  (brTarget),
    .opcode    (opcode),
    .car       (car),
    .stackFull (stackFull),
    .stackEmpty(stackEmpty),
    .ovfFlag   (stackOverflow),
    .unfFlag   (stackUnderflow)
  );

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int ADDR_W = 7,
  parameter int OP_W   = 4,
  parameter int FLAG_W = 3,
  parameter int COND_W = 2,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [COND_W-1:0] condSel,
  input logic [1:0]        brType,
  input logic [ADDR_W-1:0] brTarget,
  input logic [FLAG_W-1:0] flags,
  input logic [OP_W-1:0]   opcode,
  input logic [ADDR_W-1:0] car,
  input logic              stackOverflow,
  input logic              stackUnderflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [FLAG_W:0]   condVec;
  logic              condOk;
  logic [CNT_W-1:0]  shadowCnt;
  logic [ADDR_W-1:0] mapExp;

  assign condVec = {flags, 1'b1};
  assign condOk  = condVec[condSel];

  always_comb begin
    mapExp = '0;
    mapExp[OP_W+1:2] = opcode;
  end

  // independent count of stored return addresses
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowCnt <= '0;
    end else if (brType == 2'b01 && condOk && shadowCnt < CNT_W'(DEPTH)) begin
      shadowCnt <= shadowCnt + CNT_W'(1);
    end else if (brType == 2'b10 && shadowCnt != '0) begin
      shadowCnt <= shadowCnt - CNT_W'(1);
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (car == '0 && !stackOverflow && !stackUnderflow));

  assert_fallthrough_R2: assert property (@(posedge clk) disable iff (rst)
    (brType == 2'b00 && !condOk) |=> car == ADDR_W'($past(car) + ADDR_W'(1)));

  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (brType == 2'b00 && condOk) |=> car == $past(brTarget));

  assert_call_R4: assert property (@(posedge clk) disable iff (rst)
    (brType == 2'b01 && condOk && shadowCnt < CNT_W'(DEPTH)) |=> car == $past(brTarget));

  assert_map_R6: assert property (@(posedge clk) disable iff (rst)
    (brType == 2'b11) |=> car == $past(mapExp));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (brType == 2'b01 && condOk && shadowCnt == CNT_W'(DEPTH))
      |=> (stackOverflow && car == ADDR_W'($past(car) + ADDR_W'(1))));

  assert_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (brType == 2'b10 && shadowCnt == '0)
      |=> (stackUnderflow && car == ADDR_W'($past(car) + ADDR_W'(1))));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    stackOverflow |=> stackOverflow);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    stackUnderflow |=> stackUnderflow);

endmodule

bind useq_top useq_chk #(
  .ADDR_W(ADDR_W),
  .OP_W  (OP_W),
  .FLAG_W(FLAG_W),
  .COND_W(COND_W),
  .DEPTH (DEPTH)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .condSel       (condSel),
  .brType        (brType),
  .brTarget      (brTarget),
  .flags         (flags),
  .opcode        (opcode),
  .car           (car),
  .stackOverflow (stackOverflow),
  .stackUnderflow(stackUnderflow)
);

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] condSel = '0;
  logic [1:0] brType = '0;
  logic [6:0] brTarget = '0;
  logic [2:0] flags = '0;
  logic [3:0] opcode = '0;
  logic [6:0] car;
  logic       stackOverflow;
  logic       stackUnderflow;

  int checks = 0;
  int errors = 0;

  logic [6:0] expCar = '0;
  logic [6:0] expStk [4];
  int         expCnt = 0;
  logic       expOvf = 1'b0;
  logic       expUnf = 1'b0;

  always #5 clk = ~clk;

  useq_top dut_i (
    .clk           (clk),
    .rst           (rst),
    .condSel       (condSel),
    .brType        (brType),
    .brTarget      (brTarget),
    .flags         (flags),
    .opcode        (opcode),
    .car           (car),
    .stackOverflow (stackOverflow),
    .stackUnderflow(stackUnderflow)
  );

  function automatic string tagOf(input logic [1:0] bt);
    case (bt)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic condOf(input logic [1:0] cs, input logic [2:0] fl);
    if (cs == 2'b00) return 1'b1;
    return fl[cs - 2'd1];
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] cs, input logic [1:0] bt,
                      input logic [6:0] tgt, input logic [2:0] fl, input logic [3:0] op,
                      input string tag);
    logic ct;
    @(negedge clk);
    rst = r; condSel = cs; brType = bt; brTarget = tgt; flags = fl; opcode = op;
    ct = condOf(cs, fl);
    if (r) begin
      expCar = '0; expCnt = 0; expOvf = 1'b0; expUnf = 1'b0;
    end else begin
      case (bt)
        2'b00: expCar = ct ? tgt : expCar + 7'd1;
        2'b01: begin
          if (!ct) expCar = expCar + 7'd1;
          else if (expCnt == 4) begin expOvf = 1'b1; expCar = expCar + 7'd1; end
          else begin expStk[expCnt] = expCar + 7'd1; expCnt++; expCar = tgt; end
        end
        2'b10: begin
          if (expCnt == 0) begin expUnf = 1'b1; expCar = expCar + 7'd1; end
          else begin expCnt--; expCar = expStk[expCnt]; end
        end
        default: expCar = {1'b0, op, 2'b00};
      endcase
    end
    @(posedge clk);
    #1;
    check(tag, "car", int'(car), int'(expCar));
    check(tag, "stackOverflow", int'(stackOverflow), int'(expOvf));
    check(tag, "stackUnderflow", int'(stackUnderflow), int'(expUnf));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    int unsigned rnd;
    rnd = $urandom(32'd5150);
    // R1 reset state
    step(1'b1, 2'b00, 2'b00, 7'd0, 3'b000, 4'h0, "R1");
    step(1'b1, 2'b00, 2'b00, 7'd55, 3'b111, 4'h0, "R1");
    // R3 condition select
    step(1'b0, 2'b00, 2'b00, 7'd10, 3'b000, 4'h0, "R3");
    step(1'b0, 2'b01, 2'b00, 7'd20, 3'b001, 4'h0, "R3");
    step(1'b0, 2'b11, 2'b00, 7'd30, 3'b100, 4'h0, "R3");
    // R2 false condition and wrap
    step(1'b0, 2'b10, 2'b00, 7'd90, 3'b101, 4'h0, "R2");
    step(1'b0, 2'b00, 2'b00, 7'd127, 3'b000, 4'h0, "R3");
    step(1'b0, 2'b01, 2'b00, 7'd5, 3'b110, 4'h0, "R2");
    // R6 map ignores condition
    step(1'b0, 2'b01, 2'b11, 7'd3, 3'b000, 4'hB, "R6");
    step(1'b0, 2'b00, 2'b11, 7'd3, 3'b111, 4'hF, "R6");
    // R4 false call pushes nothing: following return underflows (R8)
    step(1'b1, 2'b00, 2'b00, 7'd0, 3'b000, 4'h0, "R1");
    step(1'b0, 2'b10, 2'b01, 7'd40, 3'b000, 4'h0, "R4");
    step(1'b0, 2'b00, 2'b10, 7'd0, 3'b000, 4'h0, "R8");
    step(1'b0, 2'b00, 2'b11, 7'd0, 3'b000, 4'h2, "R9");
    step(1'b1, 2'b00, 2'b00, 7'd0, 3'b000, 4'h0, "R1");
    // R10 four nested calls, R7 fifth call overflows
    step(1'b0, 2'b00, 2'b01, 7'd16, 3'b000, 4'h0, "R10");
    step(1'b0, 2'b01, 2'b01, 7'd32, 3'b001, 4'h0, "R10");
    step(1'b0, 2'b10, 2'b01, 7'd48, 3'b010, 4'h0, "R10");
    step(1'b0, 2'b11, 2'b01, 7'd64, 3'b100, 4'h0, "R10");
    step(1'b0, 2'b00, 2'b01, 7'd99, 3'b000, 4'h0, "R7");
    step(1'b0, 2'b00, 2'b00, 7'd70, 3'b000, 4'h0, "R9");
    // R5 returns ignore condition, come back in reverse order
    step(1'b0, 2'b01, 2'b10, 7'd0, 3'b000, 4'h0, "R10");
    step(1'b0, 2'b10, 2'b10, 7'd0, 3'b000, 4'h0, "R10");
    step(1'b0, 2'b11, 2'b10, 7'd0, 3'b000, 4'h0, "R5");
    step(1'b0, 2'b00, 2'b10, 7'd0, 3'b111, 4'h0, "R10");
    step(1'b0, 2'b00, 2'b10, 7'd0, 3'b000, 4'h0, "R8");
    step(1'b0, 2'b00, 2'b11, 7'd0, 3'b000, 4'h7, "R9");
    step(1'b1, 2'b00, 2'b00, 7'd0, 3'b000, 4'h0, "R1");
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic rr;
      rnd = $urandom;
      rr = (rnd[31:26] == 6'd0);
      step(rr, rnd[1:0], rnd[3:2], rnd[10:4], rnd[13:11], rnd[17:14],
           rr ? "R1" : tagOf(rnd[3:2]));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule